// File: doc/BRIEF.md
# Prioritized Local Interrupt Controller

This block gathers up to fifteen level-sensitive interrupt requests from local devices and merges them into a single interrupt line toward a processor. Software controls which requests may reach that line through a 16-bit mask register. Each bit of the register enables the request with the same number. Software usually changes the mask by reading it, altering one bit and writing it back. Writing zero to the whole register shuts every request off.

When the processor takes the interrupt, it reads a status word. That word names the winning request as a small code: the request number plus one, held in bits [7:2]. A code of zero means that nothing enabled is pending. When several enabled requests are pending, the lowest-numbered one wins. The two lowest bits of the same word are sticky flags, set by rising edges on two error inputs. Reading the status word clears those flags, and software does this once at start-up to discard stale events. Level requests are not latched. Any request that is still asserted and enabled appears again straight away.

The register port is a plain single-cycle strobe interface with no back-pressure. A write strobe takes effect at the clock edge. A read strobe captures the addressed word at its edge, and the word appears on the read-data pins in the next cycle. It stays there until the next read.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset the mask register is 0x0000, `irq_o` is 0, `reg_rdata` is 0 and both error flags are clear.
- R2: A write strobe at address 0x0 stores all 16 bits of `reg_wdata` into the mask register. A later read at address 0x0 returns those bits.
- R3: A read at address 0x1 returns, in bits [7:2], the lowest-numbered request n that is asserted with mask bit n set, encoded as n+1. The field is 0 when no such request exists, and bits [15:8] are always 0.
- R4: A request whose mask bit is clear has no effect on `irq_o` or on the code. Mask bit 15 has no request behind it.
- R5: `irq_o` is 1 exactly one clock after a cycle in which at least one request is asserted and enabled, and 0 one clock after a cycle in which none is.
- R6: A read returns the value the addressed word has at the clock edge that samples the strobe. `reg_rdata` holds that value until the next read strobe.
- R7: A rising edge on `err_i[k]` (k = 0 or 1) sets bit k of the status word. The bit stays set after the input falls.
- R8: A read at address 0x1 clears both error flags, unless a new rising edge arrives at the same edge, in which case that flag stays set. The read does not change the code reported for levels that are still asserted.
- R9: A write at address 0x1 changes nothing. The mask register keeps its value.
- R10: A read at any address other than 0x0 or 0x1 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address (0x0 mask, 0x1 status) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| req_i | input | 15 | Level-sensitive interrupt requests |
| err_i | input | 2 | Error event inputs, rising-edge captured |
| irq_o | output | 1 | Combined interrupt toward the processor |

## Verification
The embedded properties check several rules on every cycle:
- the one-cycle relation between enabled requests and `irq_o`;
- that the winning code points at a pending request with no lower-numbered request pending;
- the write and ignore rules of the mask register;
- the set, hold and clear rules of the error flags, including a clear that meets a new edge;
- that read data holds between strobes.

Some behaviours only show up in the bench scenarios. These include the exact code values for chosen mask and request patterns, and the read-back of data that was written. They also include the rule that a level request reappears after a clearing read, and which value a read returns when the inputs change on the strobe edge.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned CODE_W   = 6;
  localparam logic [ADDR_W-1:0] A_MASK = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h1;
endpackage

// File: rtl/lic_mask_reg.sv
module lic_mask_reg
  import lic_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q
);
  logic hit;
  assign hit = wr && (addr == AW'(A_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= '0;
    else if (hit) mask_q <= wdata;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (mask_q == $past(wdata)));                     // R2
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(mask_q));                             // R9
endmodule

// File: rtl/lic_prio_enc.sv
module lic_prio_enc
  import lic_pkg::*;
#(
  parameter int unsigned NSRC = 15,
  parameter int unsigned CW   = CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic [CW-1:0]   code,
  output logic            any
);
  logic [NSRC:0]   taken;
  logic [NSRC-1:0] win;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    assign win[i]      = pend[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | pend[i];
  end
  assign any = taken[NSRC];

  always_comb begin
    code = '0;
    for (int i = 0; i < NSRC; i++)
      if (win[i]) code = code | CW'(i + 1);
  end

  AST_CODE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> pend[code - 1'b1]);                   // R3
  AST_CODE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> ((pend & ((NSRC'(1) << (code - 1'b1)) - NSRC'(1))) == '0)); // R3
  AST_CODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (code == '0));                        // R3
endmodule

// File: rtl/lic_err_latch.sv
module lic_err_latch #(
  parameter int unsigned NERR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_i,
  input  logic            clr,
  output logic [NERR-1:0] flags
);
  logic [NERR-1:0] err_d;
  logic [NERR-1:0] rise;

  for (genvar k = 0; k < NERR; k++) begin : g_flag
    assign rise[k] = err_i[k] & ~err_d[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_d[k] <= 1'b0;
        flags[k] <= 1'b0;
      end else begin
        err_d[k] <= err_i[k];
        flags[k] <= rise[k] | (flags[k] & ~clr);
      end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rise[k] |=> flags[k]);                               // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[k] && !clr) |=> flags[k]);                    // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !rise[k]) |=> !flags[k]);                    // R8
  end
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned NSRC = 15,
  parameter int unsigned NERR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NERR-1:0]   err_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q;
  logic [NSRC-1:0]   pend;
  logic [CODE_W-1:0] code;
  logic              any;
  logic [NERR-1:0]   flags;
  logic              stat_rd;
  logic [DATA_W-1:0] stat_word;
  logic              unused_hi;

  lic_mask_reg #(.DW(DATA_W), .AW(ADDR_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .mask_q(mask_q)
  );

  assign pend      = req_i & mask_q[NSRC-1:0];
  assign unused_hi = ^mask_q[DATA_W-1:NSRC];

  lic_prio_enc #(.NSRC(NSRC), .CW(CODE_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .pend(pend), .code(code), .any(any)
  );

  assign stat_rd = reg_rd && (reg_addr == A_STAT);

  lic_err_latch #(.NERR(NERR)) u_err (
    .clk(clk), .rst_n(rst_n), .err_i(err_i), .clr(stat_rd), .flags(flags)
  );

  always_comb begin
    stat_word = '0;
    stat_word[CODE_LSB +: CODE_W] = code;
    stat_word[NERR-1:0]           = flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq_o <= any;
      if (reg_rd) begin
        case (reg_addr)
          A_MASK:  reg_rdata <= mask_q;
          A_STAT:  reg_rdata <= stat_word;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_i & mask_q[NSRC-1:0])) |=> irq_o);              // R5
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(req_i & mask_q[NSRC-1:0])) |=> !irq_o);            // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));                       // R6
  AST_RDATA_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != A_MASK && reg_addr != A_STAT) |=> (reg_rdata == '0)); // R10
endmodule

// File: tb/loc_irq_ctrl_test.sv
module loc_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [14:0] req_i = '0;
  logic [1:0]  err_i = '0;
  logic        irq_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  loc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_i(req_i), .err_i(err_i), .irq_o(irq_o)
  );

  // {mask[15:0], req[14:0], code[5:0], irq}
  localparam int NV = 9;
  localparam logic [37:0] VEC [NV] = '{
    {16'h0000, 15'h7FFF, 6'd0,  1'b0},  // R4 all masked
    {16'hFFFF, 15'h0001, 6'd1,  1'b1},  // R3
    {16'hFFFF, 15'h4000, 6'd15, 1'b1},  // R3 highest source
    {16'hFFFF, 15'h4100, 6'd9,  1'b1},  // R3 lowest wins
    {16'hFEFF, 15'h4100, 6'd15, 1'b1},  // R4 winner masked
    {16'h0010, 15'h7FEF, 6'd0,  1'b0},  // R4
    {16'h8000, 15'h7FFF, 6'd0,  1'b0},  // R4 bit 15 has no source
    {16'h00F0, 15'h0FF0, 6'd5,  1'b1},  // R3
    {16'hFFFF, 15'h0006, 6'd2,  1'b1}   // R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 rdata", reg_rdata, 16'd0);
    rst_n = 1'b1;
    rd(4'h0, v); chk("R1 mask", v, 16'h0000);
    rd(4'h1, v); chk("R1 status", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      wr(4'h0, VEC[i][37:22]);
      req_i = VEC[i][21:7];
      @(negedge clk);
      chk("R5 irq vector", {15'd0, irq_o}, {15'd0, VEC[i][0]});
      rd(4'h1, v);
      chk("R3 code vector", v, {8'd0, VEC[i][6:1], 2'b00});
    end

    // R2 / R9 / R10
    wr(4'h0, 16'hA5C3);
    rd(4'h0, v); chk("R2 readback", v, 16'hA5C3);
    wr(4'h1, 16'h1234);
    rd(4'h0, v); chk("R9 status write ignored", v, 16'hA5C3);
    rd(4'h3, v); chk("R10 unmapped", v, 16'h0000);

    // R5 latency
    wr(4'h0, 16'hFFFF);
    req_i = '0;
    @(negedge clk); @(negedge clk);
    req_i = 15'h0008;
    #1 chk("R5 not yet", {15'd0, irq_o}, 16'd0);
    @(negedge clk);
    chk("R5 rise", {15'd0, irq_o}, 16'd1);
    req_i = '0;
    @(negedge clk);
    chk("R5 fall", {15'd0, irq_o}, 16'd0);

    // R6 sample at strobe edge, then hold
    @(negedge clk);
    req_i = 15'h0008; reg_rd = 1'b1; reg_addr = 4'h1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R6 sampled at edge", reg_rdata, {8'd0, 6'd4, 2'b00});
    req_i = 15'h0002;
    @(negedge clk); @(negedge clk);
    chk("R6 hold", reg_rdata, {8'd0, 6'd4, 2'b00});

    // R7 error edge sticky
    @(negedge clk); err_i = 2'b10;
    @(negedge clk); err_i = 2'b00;
    @(negedge clk);
    rd(4'h1, v); chk("R7 sticky flag", v, {8'd0, 6'd2, 2'b10});
    rd(4'h1, v); chk("R8 cleared, level stays", v, {8'd0, 6'd2, 2'b00});

    // R8 edge coinciding with clearing read
    @(negedge clk);
    err_i = 2'b01; reg_rd = 1'b1; reg_addr = 4'h1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R8 read before edge", reg_rdata, {8'd0, 6'd2, 2'b00});
    rd(4'h1, v); chk("R8 edge survives clear", v, {8'd0, 6'd2, 2'b01});
    err_i = 2'b00;
    rd(4'h1, v); chk("R8 cleared again", v, {8'd0, 6'd2, 2'b00});

    // R4 writing zero masks everything
    wr(4'h0, 16'h0000);
    @(negedge clk);
    chk("R4 zero mask irq", {15'd0, irq_o}, 16'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule